// File: doc/BRIEF.md
# PNG Chunk Framing and Header Parser

This block sits at the front of a hardware image decoder. It takes a PNG file as a byte stream over a valid/ready handshake and checks the eight-byte file signature. It then walks the chain of chunks. From the image header chunk it pulls the width, height and colour type, validates them, and announces them with a one-cycle strobe. The colour type is given as a compact code that is numbered differently from the file's own values.

The block copies the compressed payload of every image-data chunk to an output byte stream. A flag marks the first byte of each chunk, so the inflate stage downstream can see where chunks begin. Backpressure from that stage goes straight through to the input side. All other chunk payloads are consumed and discarded, and chunk checksums are skipped.

A restart pulse must come before every image. It clears all parsing state. After the end chunk the block stops accepting bytes until the next restart. A bad signature or an unsupported header makes the block raise a sticky error flag. The rest of the stream is then drained and discarded.

Top module: `png_chunk_parser`

## Requirements
- R1: A restart pulse clears all parsing state. On the cycle after it, `err` and `hdr_stb` are low and the parser expects signature byte 0. After reset, and before the first restart, `in_ready` is low.
- R2: A byte is consumed only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while `restart` is high.
- R3: The first eight bytes must be 0x89 0x50 0x4E 0x47 0x0D 0x0A 0x1A 0x0A. A mismatching byte sets `err` on the cycle after that byte is accepted.
- R4: Each chunk is parsed as a 4-byte big-endian length, a 4-byte type, `length` payload bytes and a 4-byte checksum. The checksum is consumed without being checked. A length of zero goes straight from the type to the checksum.
- R5: In a chunk of type 0x49 0x48 0x44 0x52 (image header), payload bytes 0..3 are the width (big-endian), 4..7 the height, 8 the bit depth, 9 the colour type and 12 the interlace method. On the cycle after payload byte 12 is accepted, `hdr_stb` is high for exactly one cycle. `hdr_width`, `hdr_height` and `hdr_kind` are valid in that cycle.
- R6: `hdr_kind` maps native colour types 0, 4, 2, 6 and 3 to codes 0, 1, 2, 3 and 4 (grey, grey+alpha, RGB, RGB+alpha, indexed). Any other native value sets `err` in place of the strobe.
- R7: A bit depth other than 8, an interlace value other than 0, or a width of `MAX_W` (4000) or more sets `err` on the cycle after header byte 12. In that case `hdr_stb` is not raised.
- R8: `err` is sticky until restart. While it is set, `in_ready` stays high, every byte is discarded, and `pay_valid` and `hdr_stb` stay low.
- R9: During the payload of a chunk of type 0x49 0x44 0x41 0x54 (image data), `pay_valid` follows `in_valid`, `pay_byte` equals `in_byte`, and `in_ready` equals `pay_ready`. Payload bytes of any other chunk type are never forwarded.
- R10: `pay_first` is high together with the first forwarded byte of each image-data chunk and low for every other forwarded byte.
- R11: After the last checksum byte of a chunk of type 0x49 0x45 0x4E 0x44 (end), `in_ready` stays low until the next restart. After that restart, a new image parses normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Start-of-image pulse; clears parsing state |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Parser can take a byte this cycle |
| in_byte | input | 8 | Input stream byte |
| hdr_stb | output | 1 | One-cycle pulse: header fields valid |
| hdr_width | output | W_BITS | Image width in pixels |
| hdr_height | output | H_BITS | Image height in rows |
| hdr_kind | output | 3 | Remapped colour-type code |
| err | output | 1 | Sticky stream error |
| pay_valid | output | 1 | Image-data payload byte offered downstream |
| pay_ready | input | 1 | Downstream can take a payload byte |
| pay_byte | output | 8 | Forwarded payload byte |
| pay_first | output | 1 | First payload byte of an image-data chunk |

## Verification
The hardest state to reach from the ports is a downstream stall that falls exactly on a chunk boundary, while a second image-data chunk, possibly of zero length, is queued behind an ignored chunk. The bench builds complete byte images in a buffer and replays them with `pay_ready` throttled to one cycle in three. This makes stalls land on first bytes, last bytes and checksum transitions. The forwarded stream and its first-byte flags are compared against a list built alongside each image. Error cases are made by corrupting one field of an otherwise valid image, and the bench checks that the remainder is drained without any strobe or forwarded byte.

// File: rtl/png_parse_pkg.sv
package png_parse_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SIG, ST_LEN, ST_TYPE, ST_BODY, ST_CRC, ST_DONE, ST_DROP
  } walk_st_e;

  typedef enum logic [1:0] {
    CK_OTHER, CK_HDR, CK_DATA, CK_END
  } chunk_e;

  localparam int          OFF_W    = 4;
  localparam int          HDR_LAST = 12;
  localparam logic [31:0] TAG_HDR  = 32'h4948_4452;
  localparam logic [31:0] TAG_DATA = 32'h4944_4154;
  localparam logic [31:0] TAG_END  = 32'h4945_4E44;

  function automatic logic [7:0] sig_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    sig_byte = 8'h89;
      3'd1:    sig_byte = 8'h50;
      3'd2:    sig_byte = 8'h4E;
      3'd3:    sig_byte = 8'h47;
      3'd4:    sig_byte = 8'h0D;
      3'd5:    sig_byte = 8'h0A;
      3'd6:    sig_byte = 8'h1A;
      default: sig_byte = 8'h0A;
    endcase
  endfunction

  function automatic chunk_e classify(input logic [31:0] tag);
    if (tag == TAG_HDR)       classify = CK_HDR;
    else if (tag == TAG_DATA) classify = CK_DATA;
    else if (tag == TAG_END)  classify = CK_END;
    else                      classify = CK_OTHER;
  endfunction

  // {legal, code}
  function automatic logic [3:0] map_kind(input logic [7:0] native);
    case (native)
      8'd0:    map_kind = 4'b1_000;
      8'd4:    map_kind = 4'b1_001;
      8'd2:    map_kind = 4'b1_010;
      8'd6:    map_kind = 4'b1_011;
      8'd3:    map_kind = 4'b1_100;
      default: map_kind = 4'b0_000;
    endcase
  endfunction

endpackage

// File: rtl/png_chunk_walker.sv
module png_chunk_walker
  import png_parse_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             take,
  input  logic             fault,
  input  logic [7:0]       in_byte,
  output walk_st_e         st,
  output chunk_e           kind,
  output logic [OFF_W-1:0] off
);

  localparam logic [OFF_W-1:0] OFF_MAX = {OFF_W{1'b1}};

  walk_st_e         st_q, st_d;
  chunk_e           kind_q, kind_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [2:0]       cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [23:0]      tag_q, tag_d;
  logic [31:0]      tag_full;

  assign tag_full = {tag_q, in_byte};

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    off_d  = off_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    rem_d  = rem_q;
    tag_d  = tag_q;
    if (restart) begin
      st_d   = ST_SIG;
      kind_d = CK_OTHER;
      off_d  = '0;
      cnt_d  = '0;
      len_d  = '0;
      rem_d  = '0;
      tag_d  = '0;
    end else if (take) begin
      unique case (st_q)
        ST_SIG: begin
          if (in_byte != sig_byte(cnt_q)) begin
            st_d = ST_DROP;
          end else if (cnt_q == 3'd7) begin
            st_d  = ST_LEN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 3'd1;
          end
        end
        ST_LEN: begin
          len_d = {len_q[LEN_W-9:0], in_byte};
          if (cnt_q == 3'd3) begin
            st_d  = ST_TYPE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 3'd1;
          end
        end
        ST_TYPE: begin
          tag_d = {tag_q[15:0], in_byte};
          if (cnt_q == 3'd3) begin
            kind_d = classify(tag_full);
            cnt_d  = '0;
            off_d  = '0;
            rem_d  = len_q;
            st_d   = (len_q == '0) ? ST_CRC : ST_BODY;
          end else begin
            cnt_d = cnt_q + 3'd1;
          end
        end
        ST_BODY: begin
          rem_d = rem_q - LEN_W'(1);
          off_d = (off_q == OFF_MAX) ? OFF_MAX : off_q + OFF_W'(1);
          if (rem_q == LEN_W'(1)) begin
            st_d  = ST_CRC;
            cnt_d = '0;
          end
        end
        ST_CRC: begin
          if (cnt_q == 3'd3) begin
            st_d  = (kind_q == CK_END) ? ST_DONE : ST_LEN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 3'd1;
          end
        end
        default: st_d = st_q;
      endcase
      if (fault) st_d = ST_DROP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= CK_OTHER;
      off_q  <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      rem_q  <= '0;
      tag_q  <= '0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      off_q  <= off_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      rem_q  <= rem_d;
      tag_q  <= tag_d;
    end
  end

  assign st   = st_q;
  assign kind = kind_q;
  assign off  = off_q;

endmodule

// File: rtl/png_hdr_fields.sv
module png_hdr_fields
  import png_parse_pkg::*;
#(
  parameter int W_BITS = 12,
  parameter int H_BITS = 32,
  parameter int MAX_W  = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              grab,
  input  logic [OFF_W-1:0]  off,
  input  logic [7:0]        in_byte,
  output logic              fault,
  output logic              hdr_stb,
  output logic [W_BITS-1:0] hdr_width,
  output logic [H_BITS-1:0] hdr_height,
  output logic [2:0]        hdr_kind
);

  localparam logic [31:0] W_LIMIT = 32'(MAX_W);

  logic [31:0]       w_acc_q, w_acc_d;
  logic [31:0]       h_acc_q, h_acc_d;
  logic [7:0]        depth_q, depth_d;
  logic [7:0]        ctype_q, ctype_d;
  logic              stb_q, stb_d;
  logic [W_BITS-1:0] wid_q, wid_d;
  logic [H_BITS-1:0] hgt_q, hgt_d;
  logic [2:0]        kind_q, kind_d;
  logic [3:0]        mapped;
  logic              hdr_ok;

  assign mapped = map_kind(ctype_q);
  assign hdr_ok = mapped[3] && (depth_q == 8'd8) && (in_byte == 8'd0)
                  && (w_acc_q < W_LIMIT);

  always_comb begin
    w_acc_d = w_acc_q;
    h_acc_d = h_acc_q;
    depth_d = depth_q;
    ctype_d = ctype_q;
    stb_d   = 1'b0;
    wid_d   = wid_q;
    hgt_d   = hgt_q;
    kind_d  = kind_q;
    fault   = 1'b0;
    if (restart) begin
      w_acc_d = '0;
      h_acc_d = '0;
      depth_d = '0;
      ctype_d = '0;
    end else if (grab) begin
      if (off < OFF_W'(4)) begin
        w_acc_d = {w_acc_q[23:0], in_byte};
      end else if (off < OFF_W'(8)) begin
        h_acc_d = {h_acc_q[23:0], in_byte};
      end else if (off == OFF_W'(8)) begin
        depth_d = in_byte;
      end else if (off == OFF_W'(9)) begin
        ctype_d = in_byte;
      end else if (off == OFF_W'(HDR_LAST)) begin
        if (hdr_ok) begin
          stb_d  = 1'b1;
          wid_d  = w_acc_q[W_BITS-1:0];
          hgt_d  = h_acc_q[H_BITS-1:0];
          kind_d = mapped[2:0];
        end else begin
          fault = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_acc_q <= '0;
      h_acc_q <= '0;
      depth_q <= '0;
      ctype_q <= '0;
      stb_q   <= 1'b0;
      wid_q   <= '0;
      hgt_q   <= '0;
      kind_q  <= '0;
    end else begin
      w_acc_q <= w_acc_d;
      h_acc_q <= h_acc_d;
      depth_q <= depth_d;
      ctype_q <= ctype_d;
      stb_q   <= stb_d;
      wid_q   <= wid_d;
      hgt_q   <= hgt_d;
      kind_q  <= kind_d;
    end
  end

  assign hdr_stb    = stb_q;
  assign hdr_width  = wid_q;
  assign hdr_height = hgt_q;
  assign hdr_kind   = kind_q;

endmodule

// File: rtl/png_chunk_parser.sv
module png_chunk_parser
  import png_parse_pkg::*;
#(
  parameter int W_BITS = 12,
  parameter int H_BITS = 32,
  parameter int MAX_W  = 4000,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              hdr_stb,
  output logic [W_BITS-1:0] hdr_width,
  output logic [H_BITS-1:0] hdr_height,
  output logic [2:0]        hdr_kind,
  output logic              err,
  output logic              pay_valid,
  input  logic              pay_ready,
  output logic [7:0]        pay_byte,
  output logic              pay_first
);

  walk_st_e         st;
  chunk_e           kind;
  logic [OFF_W-1:0] off;
  logic             take;
  logic             grab;
  logic             fault;
  logic             rdy;
  logic             in_data;

  assign in_data = (st == ST_BODY) && (kind == CK_DATA);

  always_comb begin
    case (st)
      ST_SIG, ST_LEN, ST_TYPE, ST_CRC, ST_DROP: rdy = 1'b1;
      ST_BODY:                                 rdy = (kind == CK_DATA) ? pay_ready : 1'b1;
      default:                                 rdy = 1'b0;
    endcase
  end

  assign in_ready  = rdy & ~restart;
  assign take      = in_valid & in_ready;
  assign grab      = take && (st == ST_BODY) && (kind == CK_HDR);

  assign pay_valid = in_data & in_valid & ~restart;
  assign pay_byte  = in_byte;
  assign pay_first = pay_valid && (off == '0);
  assign err       = (st == ST_DROP);

  png_chunk_walker #(
    .LEN_W (LEN_W)
  ) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .take    (take),
    .fault   (fault),
    .in_byte (in_byte),
    .st      (st),
    .kind    (kind),
    .off     (off)
  );

  png_hdr_fields #(
    .W_BITS (W_BITS),
    .H_BITS (H_BITS),
    .MAX_W  (MAX_W)
  ) u_hdr (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .grab       (grab),
    .off        (off),
    .in_byte    (in_byte),
    .fault      (fault),
    .hdr_stb    (hdr_stb),
    .hdr_width  (hdr_width),
    .hdr_height (hdr_height),
    .hdr_kind   (hdr_kind)
  );

endmodule

// File: rtl/png_chunk_parser_chk.sv
module png_chunk_parser_chk #(
  parameter int W_BITS = 12,
  parameter int MAX_W  = 4000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              in_valid,
  input logic              in_ready,
  input logic              hdr_stb,
  input logic [W_BITS-1:0] hdr_width,
  input logic [2:0]        hdr_kind,
  input logic              err,
  input logic              pay_valid,
  input logic              pay_ready,
  input logic              pay_first
);

  // R1
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!err && !hdr_stb));

  // R2
  restart_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !in_ready);

  // R5
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_stb |=> !hdr_stb);

  // R6
  kind_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_stb |-> (hdr_kind <= 3'd4));

  // R7
  width_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_stb |-> (32'(hdr_width) < 32'(MAX_W)));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !restart) |=> err);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!pay_valid && !hdr_stb && (in_ready || restart)));

  // R9
  pay_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> (in_valid && (in_ready == pay_ready)));

  // R10
  first_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_first |-> pay_valid);

endmodule

bind png_chunk_parser png_chunk_parser_chk #(
  .W_BITS (W_BITS),
  .MAX_W  (MAX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .hdr_stb   (hdr_stb),
  .hdr_width (hdr_width),
  .hdr_kind  (hdr_kind),
  .err       (err),
  .pay_valid (pay_valid),
  .pay_ready (pay_ready),
  .pay_first (pay_first)
);

// File: tb/sim_png_chunk_parser.sv
module sim_png_chunk_parser;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        restart;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_byte;
  logic        hdr_stb;
  logic [11:0] hdr_width;
  logic [31:0] hdr_height;
  logic [2:0]  hdr_kind;
  logic        err;
  logic        pay_valid;
  logic        pay_ready;
  logic [7:0]  pay_byte;
  logic        pay_first;

  png_chunk_parser u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_byte    (in_byte),
    .hdr_stb    (hdr_stb),
    .hdr_width  (hdr_width),
    .hdr_height (hdr_height),
    .hdr_kind   (hdr_kind),
    .err        (err),
    .pay_valid  (pay_valid),
    .pay_ready  (pay_ready),
    .pay_byte   (pay_byte),
    .pay_first  (pay_first)
  );

  int total = 0;
  int fails = 0;

  logic [7:0] img [0:255];
  int         img_n;
  logic [7:0] exp_pay [0:63];
  logic       exp_first [0:63];
  int         exp_n;
  logic [7:0] pay_log [0:63];
  logic       first_log [0:63];
  int         pay_n;
  int         stb_n;
  logic [11:0] got_w;
  logic [31:0] got_h;
  logic [2:0]  got_k;
  logic        stall;
  int          stall_ph;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    stall_ph  = stall_ph + 1;
    pay_ready = !stall || (stall_ph % 3 == 0);
  end

  always @(negedge clk) begin
    #1;
    if (pay_valid && pay_ready) begin
      if (pay_n < 64) begin
        pay_log[pay_n]   = pay_byte;
        first_log[pay_n] = pay_first;
      end
      pay_n = pay_n + 1;
    end
    if (hdr_stb) begin
      stb_n = stb_n + 1;
      got_w = hdr_width;
      got_h = hdr_height;
      got_k = hdr_kind;
    end
  end

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    total = total + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails = fails + 1;
    total = total + 1;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  // image builder
  task automatic put(input logic [7:0] b);
    img[img_n] = b;
    img_n = img_n + 1;
  endtask

  task automatic put32(input logic [31:0] v);
    put(v[31:24]); put(v[23:16]); put(v[15:8]); put(v[7:0]);
  endtask

  task automatic new_image();
    img_n = 0;
    exp_n = 0;
    put32(32'h8950_4E47);
    put32(32'h0D0A_1A0A);
  endtask

  task automatic add_hdr(input logic [31:0] w, input logic [31:0] h,
                         input logic [7:0] depth, input logic [7:0] ctype,
                         input logic [7:0] il);
    put32(32'd13); put32(32'h4948_4452);
    put32(w); put32(h);
    put(depth); put(ctype); put(8'd0); put(8'd0); put(il);
    put32(32'h1234_5678);
  endtask

  task automatic add_data(input int n, input logic [7:0] seed);
    put32(32'(n)); put32(32'h4944_4154);
    for (int i = 0; i < n; i++) begin
      put(seed + 8'(i));
      exp_pay[exp_n]   = seed + 8'(i);
      exp_first[exp_n] = (i == 0);
      exp_n = exp_n + 1;
    end
    put32(32'hCAFE_F00D);
  endtask

  task automatic add_other(input int n);
    put32(32'(n)); put32(32'h7445_5874);
    for (int i = 0; i < n; i++) put(8'hE0 + 8'(i));
    put32(32'h0BAD_0BAD);
  endtask

  task automatic add_end();
    put32(32'd0); put32(32'h4945_4E44); put32(32'hAE42_6082);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    #1;
    while (in_ready !== 1'b1) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_range(input int from, input int upto);
    for (int i = from; i < upto; i++) send(img[i]);
  endtask

  task automatic pulse_restart();
    @(negedge clk);
    restart  = 1'b1;
    in_valid = 1'b0;
    #1;
    check("R2", "in_ready during restart", in_ready, 0);
    @(negedge clk);
    restart = 1'b0;
    pay_n = 0;
    stb_n = 0;
  endtask

  task automatic check_payload(input string req);
    check(req, "forwarded byte count", pay_n, exp_n);
    for (int i = 0; i < exp_n && i < pay_n; i++) begin
      check(req, "forwarded byte", pay_log[i], exp_pay[i]);
      check("R10", "first flag", first_log[i], exp_first[i]);
    end
  endtask

  // scenarios
  task automatic t_reset();
    #1;
    check("R1", "in_ready after reset", in_ready, 0);
    check("R1", "err after reset", err, 0);
    check("R5", "hdr_stb after reset", hdr_stb, 0);
    check("R9", "pay_valid after reset", pay_valid, 0);
  endtask

  task automatic t_basic();
    pulse_restart();
    #1;
    check("R1", "in_ready after restart", in_ready, 1);
    check("R1", "err after restart", err, 0);
    new_image();
    add_hdr(32'd4, 32'd2, 8'd8, 8'd2, 8'd0);
    add_data(5, 8'h10);
    add_end();
    send_range(0, img_n);
    #1;
    check("R5", "header strobes", stb_n, 1);
    check("R5", "width", got_w, 4);
    check("R5", "height", got_h, 2);
    check("R6", "rgb code", got_k, 2);
    check("R4", "err after clean image", err, 0);
    check_payload("R9");
    check("R11", "in_ready after end chunk", in_ready, 0);
    // R2: bytes offered after the end are not taken
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = 8'h55;
    repeat (3) @(negedge clk);
    #1;
    check("R2", "ready stays low when done", in_ready, 0);
    check("R11", "no forwarding when done", pay_n, exp_n);
    in_valid = 1'b0;
  endtask

  task automatic t_stb_timing();
    pulse_restart();
    new_image();
    add_hdr(32'd640, 32'd480, 8'd8, 8'd0, 8'd0);
    add_end();
    send_range(0, 8 + 8 + 12);
    #1;
    check("R5", "no strobe before byte 12", hdr_stb, 0);
    send(img[28]);
    #1;
    check("R5", "strobe after byte 12", hdr_stb, 1);
    check("R5", "width at strobe", hdr_width, 640);
    check("R5", "height at strobe", hdr_height, 480);
    @(negedge clk);
    #1;
    check("R5", "strobe is one cycle", hdr_stb, 0);
    send_range(29, img_n);
  endtask

  task automatic t_multi();
    pulse_restart();
    stall = 1'b1;
    new_image();
    add_hdr(32'd300, 32'd7, 8'd8, 8'd6, 8'd0);
    add_other(3);
    add_data(4, 8'h40);
    add_data(0, 8'h00);
    add_other(0);
    add_data(3, 8'h80);
    add_end();
    send_range(0, img_n);
    stall = 1'b0;
    #1;
    check("R6", "rgb+alpha code", got_k, 3);
    check("R5", "width 300", got_w, 300);
    check("R4", "err with zero-length chunks", err, 0);
    check_payload("R9");
    check("R11", "done after multi-chunk image", in_ready, 0);
  endtask

  task automatic t_kinds();
    logic [7:0] nat [0:2];
    logic [2:0] code [0:2];
    nat[0] = 8'd0; code[0] = 3'd0;
    nat[1] = 8'd4; code[1] = 3'd1;
    nat[2] = 8'd3; code[2] = 3'd4;
    for (int k = 0; k < 3; k++) begin
      pulse_restart();
      new_image();
      add_hdr(32'd1, 32'd1, 8'd8, nat[k], 8'd0);
      add_end();
      send_range(0, img_n);
      #1;
      check("R6", "mapped colour code", got_k, code[k]);
      check("R6", "strobe for legal type", stb_n, 1);
    end
    pulse_restart();
    new_image();
    add_hdr(32'd1, 32'd1, 8'd8, 8'd5, 8'd0);
    add_end();
    send_range(0, img_n);
    #1;
    check("R6", "illegal type sets err", err, 1);
    check("R6", "no strobe for illegal type", stb_n, 0);
  endtask

  task automatic t_bad_sig();
    pulse_restart();
    new_image();
    img[2] = 8'h4F;
    add_hdr(32'd2, 32'd2, 8'd8, 8'd2, 8'd0);
    add_data(2, 8'h20);
    add_end();
    send_range(0, 2);
    #1;
    check("R3", "err before bad byte", err, 0);
    send(img[2]);
    #1;
    check("R3", "err after bad signature byte", err, 1);
    send_range(3, img_n);
    #1;
    check("R8", "err still set", err, 1);
    check("R8", "ready held high while draining", in_ready, 1);
    check("R8", "nothing forwarded after err", pay_n, 0);
    check("R8", "no strobe after err", stb_n, 0);
    pulse_restart();
    #1;
    check("R1", "restart clears err", err, 0);
    new_image();
    add_hdr(32'd9, 32'd3, 8'd8, 8'd2, 8'd0);
    add_data(2, 8'h70);
    add_end();
    send_range(0, img_n);
    #1;
    check("R11", "image after error recovers", stb_n, 1);
    check_payload("R11");
  endtask

  task automatic one_hdr(input logic [31:0] w, input logic [7:0] depth,
                         input logic [7:0] il, input string what,
                         input logic exp_err);
    pulse_restart();
    new_image();
    add_hdr(w, 32'd5, depth, 8'd2, il);
    add_data(1, 8'h33);
    add_end();
    send_range(0, img_n);
    #1;
    check("R7", what, err, exp_err);
    check("R7", {what, " strobe"}, stb_n, exp_err ? 0 : 1);
  endtask

  task automatic t_bad_hdr();
    one_hdr(32'd4, 8'd16, 8'd0, "depth 16", 1'b1);
    one_hdr(32'd4, 8'd8, 8'd1, "interlaced", 1'b1);
    one_hdr(32'd4000, 8'd8, 8'd0, "width 4000", 1'b1);
    one_hdr(32'd3999, 8'd8, 8'd0, "width 3999", 1'b0);
    check("R7", "width 3999 reported", got_w, 3999);
  endtask

  task automatic t_restart_mid();
    pulse_restart();
    new_image();
    add_hdr(32'd77, 32'd5, 8'd8, 8'd2, 8'd0);
    send_range(0, 14);
    pulse_restart();
    new_image();
    add_hdr(32'd12, 32'd34, 8'd8, 8'd4, 8'd0);
    add_data(3, 8'hA0);
    add_end();
    send_range(0, img_n);
    #1;
    check("R1", "strobe after mid-stream restart", stb_n, 1);
    check("R1", "width after mid-stream restart", got_w, 12);
    check("R6", "grey+alpha code", got_k, 1);
    check_payload("R1");
  endtask

  initial begin
    rst_n    = 1'b0;
    restart  = 1'b0;
    in_valid = 1'b0;
    in_byte  = 8'h00;
    stall    = 1'b0;
    stall_ph = 0;
    pay_ready = 1'b1;
    pay_n = 0;
    stb_n = 0;
    got_w = '0;
    got_h = '0;
    got_k = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_stb_timing();
    t_multi();
    t_kinds();
    t_bad_sig();
    t_bad_hdr();
    t_restart_mid();
    summary();
  end

endmodule